// File: doc/BRIEF.md
# Multiplexed LCD Frame Drive Sequencer

This block turns a small display memory into the drive pattern for a glass panel with four common lines and twenty segment lines, using 1/4 duty and 1/3 bias. An oscillator tick advances its timing. The block keeps its own common scan, drive polarity and blink timing. It reads one common row of the display memory at a time through a combinational read port: it presents the row index and receives the twenty bits of that row in the same cycle.

Each common and segment output is a 2-bit level code, which an analog buffer stage outside the block turns into a voltage. The codes are 0 for the low rail, 1 for one third, 2 for two thirds and 3 for the high rail. The controls select the frame length, line or frame inversion, display on or off, blink rate, and forcing every segment on or off. Display-off is synchronous to the frame: the block completes the current frame, sends one frame of blank data, and then parks every output at level 0.

Top module: `lcd_frame_seq`

## Requirements
- R1: While reset is held and after its release with the display off, every common and segment code is 0 and the row index is 0.
- R2: A common period lasts a quarter of the frame: 128, 144, 162 or 192 ticks for frame select 0, 1, 2 and 3 (frames of 512, 576, 648 and 768 ticks). Commons are scanned 0, 1, 2, 3 in turn, and the row index equals the common being scanned.
- R3: While driving, exactly one common sits at a rail: code 3 under positive polarity, code 0 under negative. Every other common is at code 1 (positive) or code 2 (negative).
- R4: Segment s takes bit s of the row read for the scanned common. Under positive polarity, lit is code 0 and dark is code 2. Under negative polarity, lit is code 3 and dark is code 1.
- R5: With inversion bit 0 (line mode), polarity toggles at the end of every common period.
- R6: With inversion bit 1 (frame mode), polarity toggles only when common 3's period ends.
- R7: When display-on drops, the current frame completes, then one frame is sent with normal commons and all segments dark, then all outputs go to code 0.
- R8: Forcing all segments on makes every segment lit. Forcing all segments off makes every segment dark. Off wins if both are set. Both are ignored during the blank exit frame and while the display is off.
- R9: Blink select 1, 2 and 3 alternate a shown half and a dark half of 40960, 20480 and 10240 ticks, shown half first. Select 0 never darkens segments.
- R10: Raising display-on from the off state starts at common 0, positive polarity, on the next clock edge.
- R11: Clock cycles without a tick leave the scan position and polarity unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscTick | input | 1 | Oscillator tick, one-cycle enable |
| dispOn | input | 1 | Display enable level |
| frameSel | input | 2 | Frame length select |
| invMode | input | 1 | 0 line inversion, 1 frame inversion |
| blinkSel | input | 2 | Blink rate select |
| allOn | input | 1 | Force all segments lit |
| allOff | input | 1 | Force all segments dark |
| rowSel | output | 2 | Common row index to the display memory |
| rowBits | input | 20 | Row data for rowSel, bit s drives segment s |
| comDrive | output | 8 | Common level codes, 2 bits per common, common 0 in bits 1:0 |
| segDrive | output | 40 | Segment level codes, 2 bits per segment, segment 0 in bits 1:0 |

## Verification
The assertions assume that rowBits is a pure function of rowSel during a cycle, and that the controls change only between clock edges. The polarity and dark-segment properties also assume that nothing else holds the outputs at code 0 while the display is driven. The stimulus meets these assumptions by modelling the memory as a bench array indexed by rowSel and by changing the controls only on the falling clock edge. Mode, tick and memory changes are randomized, so frame-length switches and display toggles land mid-period.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  localparam int NUM_COM = 4;
  localparam int COM_W   = $clog2(NUM_COM);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_EXIT = 2'd2
  } scanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             active;    // outputs driven
    logic             allowPix;  // all-pixel forcing honoured
    logic             segDark;   // every segment forced dark
    logic             pol;       // 0 positive, 1 negative
    logic [COM_W-1:0] comIdx;
  } scanStrobe_t;

  function automatic int frameTicks(input logic [1:0] sel);
    case (sel)
      2'd0:    return 512;
      2'd1:    return 576;
      2'd2:    return 648;
      default: return 768;
    endcase
  endfunction

endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_seq_pkg::*;
#(
  parameter int BLINK_BASE = 40960
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        oscTick,
  input  logic        dispOn,
  input  logic [1:0]  frameSel,
  input  logic        invMode,
  input  logic [1:0]  blinkSel,
  output scanStrobe_t strobe
);

  localparam int PH_W = $clog2(768 / NUM_COM);
  localparam int BL_W = $clog2(BLINK_BASE);

  scanState_t       state;
  logic [PH_W-1:0]  phase;
  logic [PH_W-1:0]  comLen;
  logic [COM_W-1:0] comIdx;
  logic             pol;
  logic [BL_W-1:0]  blinkCnt;
  logic [BL_W-1:0]  halfLen;
  logic             blankHalf;
  logic             periodEnd;
  logic             frameEnd;

  always_comb begin
    comLen    = PH_W'(frameTicks(frameSel) / NUM_COM);
    halfLen   = BL_W'(BLINK_BASE >> (blinkSel - 2'd1));
    periodEnd = oscTick && (phase >= comLen - 1'b1);
    frameEnd  = periodEnd && (comIdx == COM_W'(NUM_COM - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= '0;
      comIdx <= '0;
      pol    <= 1'b0;
    end else if (state == ST_IDLE) begin
      phase  <= '0;
      comIdx <= '0;
      pol    <= 1'b0;
      if (dispOn) state <= ST_RUN;
    end else if (periodEnd) begin
      phase  <= '0;
      comIdx <= comIdx + 1'b1;
      if (!invMode || frameEnd) pol <= ~pol;
      if (frameEnd) begin
        if (state == ST_RUN && !dispOn) state <= ST_EXIT;
        else if (state == ST_EXIT) state <= dispOn ? ST_RUN : ST_IDLE;
      end
    end else if (oscTick) begin
      phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || state == ST_IDLE || blinkSel == 2'd0) begin
      blinkCnt  <= '0;
      blankHalf <= 1'b0;
    end else if (oscTick) begin
      if (blinkCnt >= halfLen - 1'b1) begin
        blinkCnt  <= '0;
        blankHalf <= ~blankHalf;
      end else begin
        blinkCnt <= blinkCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.active   = (state != ST_IDLE);
    strobe.allowPix = (state == ST_RUN);
    strobe.segDark  = (state == ST_EXIT) || (state == ST_RUN && blankHalf);
    strobe.pol      = pol;
    strobe.comIdx   = comIdx;
  end

endmodule

// File: rtl/lcd_drive_path.sv
module lcd_drive_path
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG = 20
) (
  input  scanStrobe_t            strobe,
  input  logic [NUM_SEG-1:0]     rowBits,
  input  logic                   allOn,
  input  logic                   allOff,
  output logic [2*NUM_COM-1:0]   comDrive,
  output logic [2*NUM_SEG-1:0]   segDrive
);

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    always_comb begin
      if (!strobe.active)
        comDrive[2*c +: 2] = 2'd0;
      else if (strobe.comIdx == COM_W'(c))
        comDrive[2*c +: 2] = strobe.pol ? 2'd0 : 2'd3;
      else
        comDrive[2*c +: 2] = strobe.pol ? 2'd2 : 2'd1;
    end
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic lit;
    always_comb begin
      lit = rowBits[s];
      if (strobe.allowPix) begin
        if (allOff)     lit = 1'b0;
        else if (allOn) lit = 1'b1;
      end
      if (strobe.segDark) lit = 1'b0;
      if (!strobe.active)
        segDrive[2*s +: 2] = 2'd0;
      else if (strobe.pol)
        segDrive[2*s +: 2] = lit ? 2'd3 : 2'd1;
      else
        segDrive[2*s +: 2] = lit ? 2'd0 : 2'd2;
    end
  end

endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG    = 20,
  parameter int BLINK_BASE = 40960
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 oscTick,
  input  logic                 dispOn,
  input  logic [1:0]           frameSel,
  input  logic                 invMode,
  input  logic [1:0]           blinkSel,
  input  logic                 allOn,
  input  logic                 allOff,
  output logic [1:0]           rowSel,
  input  logic [NUM_SEG-1:0]   rowBits,
  output logic [2*NUM_COM-1:0] comDrive,
  output logic [2*NUM_SEG-1:0] segDrive
);

  scanStrobe_t strobe;

  lcd_scan_ctrl #(.BLINK_BASE(BLINK_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .dispOn(dispOn),
    .frameSel(frameSel), .invMode(invMode), .blinkSel(blinkSel),
    .strobe(strobe)
  );

  lcd_drive_path #(.NUM_SEG(NUM_SEG)) u_path (
    .strobe(strobe), .rowBits(rowBits), .allOn(allOn), .allOff(allOff),
    .comDrive(comDrive), .segDrive(segDrive)
  );

  assign rowSel = strobe.comIdx;

endmodule

// File: rtl/lcd_frame_seq_chk.sv
module lcd_frame_seq_chk
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG = 20
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 oscTick,
  input logic                 allOff,
  input logic [1:0]           rowSel,
  input logic [2*NUM_COM-1:0] comDrive,
  input logic [2*NUM_SEG-1:0] segDrive
);

  logic [NUM_COM-1:0] comRail;
  logic               anyHigh;
  logic               segAllDark, segPosOk, segNegOk;

  always_comb begin
    anyHigh = 1'b0;
    for (int c = 0; c < NUM_COM; c++) begin
      comRail[c] = (comDrive[2*c +: 2] == 2'd0) || (comDrive[2*c +: 2] == 2'd3);
      if (comDrive[2*c +: 2] == 2'd3) anyHigh = 1'b1;
    end
    segAllDark = 1'b1;
    segPosOk   = 1'b1;
    segNegOk   = 1'b1;
    for (int s = 0; s < NUM_SEG; s++) begin
      if (segDrive[2*s +: 2] == 2'd0 || segDrive[2*s +: 2] == 2'd3) segAllDark = 1'b0;
      if (segDrive[2*s +: 2] == 2'd1 || segDrive[2*s +: 2] == 2'd3) segPosOk   = 1'b0;
      if (segDrive[2*s +: 2] == 2'd0 || segDrive[2*s +: 2] == 2'd2) segNegOk   = 1'b0;
    end
  end

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (comDrive == '0) |-> (segDrive == '0));

  // R3
  one_rail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (comDrive != '0) |-> ($countones(comRail) == 1));

  // R4
  seg_polarity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (comDrive != '0) |-> (anyHigh ? segPosOk : segNegOk));

  // R8
  all_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (allOff && comDrive != '0) |-> segAllDark);

  // R11
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oscTick |=> $stable(rowSel));

  // R2
  scan_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rowSel == $past(rowSel)) || (rowSel == $past(rowSel) + 2'd1));

endmodule

bind lcd_frame_seq lcd_frame_seq_chk #(.NUM_SEG(NUM_SEG)) u_chk (.*);

// File: tb/lcd_frame_seq_bench.sv
module lcd_frame_seq_bench;

  localparam int NSEG = 20;
  localparam int NCOM = 4;

  logic clk = 1'b0;
  logic rstN, oscTick, dispOn, invMode, allOn, allOff;
  logic [1:0] frameSel, blinkSel, rowSel;
  logic [NSEG-1:0] rowBits;
  logic [2*NCOM-1:0] comDrive;
  logic [2*NSEG-1:0] segDrive;
  logic [NSEG-1:0] mem [NCOM];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  int mState = 0;  // 0 off, 1 run, 2 exit frame
  int mPhase = 0, mCom = 0, mPol = 0, mBlinkCnt = 0, mBlank = 0;

  always #2.5 clk = ~clk;
  assign rowBits = mem[rowSel];

  lcd_frame_seq u_lcd_frame_seq (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .dispOn(dispOn),
    .frameSel(frameSel), .invMode(invMode), .blinkSel(blinkSel),
    .allOn(allOn), .allOff(allOff), .rowSel(rowSel), .rowBits(rowBits),
    .comDrive(comDrive), .segDrive(segDrive)
  );

  function automatic int comPeriod(input logic [1:0] sel);
    case (sel)
      2'd0: return 128;
      2'd1: return 144;
      2'd2: return 162;
      default: return 192;
    endcase
  endfunction

  function automatic int blinkHalf(input logic [1:0] sel);
    case (sel)
      2'd1: return 40960;
      2'd2: return 20480;
      default: return 10240;
    endcase
  endfunction

  function automatic logic [2*NCOM-1:0] expCom();
    logic [2*NCOM-1:0] v = '0;
    if (mState != 0)
      for (int c = 0; c < NCOM; c++)
        v[2*c +: 2] = (c == mCom) ? (mPol ? 2'd0 : 2'd3) : (mPol ? 2'd2 : 2'd1);
    return v;
  endfunction

  function automatic logic [2*NSEG-1:0] expSeg();
    logic [2*NSEG-1:0] v = '0;
    logic lit;
    if (mState != 0)
      for (int s = 0; s < NSEG; s++) begin
        lit = mem[mCom][s];
        if (mState == 1) begin
          if (allOff) lit = 1'b0;
          else if (allOn) lit = 1'b1;
          if (mBlank != 0) lit = 1'b0;
        end else lit = 1'b0;
        v[2*s +: 2] = mPol ? (lit ? 2'd3 : 2'd1) : (lit ? 2'd0 : 2'd2);
      end
    return v;
  endfunction

  task automatic modelAdvance();
    bit fEnd;
    if (mState == 0) begin
      mPhase = 0; mCom = 0; mPol = 0;
      if (dispOn) mState = 1;
    end else if (oscTick) begin
      if (mPhase >= comPeriod(frameSel) - 1) begin
        fEnd = (mCom == NCOM - 1);
        mPhase = 0;
        mCom = (mCom + 1) % NCOM;
        if (!invMode || fEnd) mPol = 1 - mPol;
        if (fEnd) begin
          if (mState == 1 && !dispOn) mState = 2;
          else if (mState == 2) mState = dispOn ? 1 : 0;
        end
      end else mPhase++;
    end
  endtask

  task automatic blinkAdvance(input int prevState);
    if (prevState == 0 || blinkSel == 2'd0) begin
      mBlinkCnt = 0; mBlank = 0;
    end else if (oscTick) begin
      if (mBlinkCnt >= blinkHalf(blinkSel) - 1) begin
        mBlinkCnt = 0; mBlank = 1 - mBlank;
      end else mBlinkCnt++;
    end
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    int prev;
    @(posedge clk);
    prev = mState;
    modelAdvance();
    blinkAdvance(prev);
    @(negedge clk);
    check({tag, " com"}, 64'(comDrive), 64'(expCom()));
    check({tag, " seg"}, 64'(segDrive), 64'(expSeg()));
    check({tag, " row"}, 64'(rowSel), 64'(mCom));
  endtask

  function automatic bit allSegIn(input logic [1:0] a, input logic [1:0] b);
    for (int s = 0; s < NSEG; s++)
      if (segDrive[2*s +: 2] != a && segDrive[2*s +: 2] != b) return 1'b0;
    return 1'b1;
  endfunction

  initial begin : main
    logic [2*NSEG-1:0] segSnap;
    logic [2*NCOM-1:0] comSnap;
    void'($urandom(32'd1796));
    rstN = 0; oscTick = 0; dispOn = 0; invMode = 0; allOn = 0; allOff = 0;
    frameSel = 0; blinkSel = 0;
    for (int c = 0; c < NCOM; c++) mem[c] = NSEG'($urandom);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset com", 64'(comDrive), 64'd0);
    check("R1 reset seg", 64'(segDrive), 64'd0);
    check("R1 reset row", 64'(rowSel), 64'd0);
    rstN = 1;
    oscTick = 1;
    repeat (4) step("R1 idle");
    // R10 start from common 0, positive
    dispOn = 1;
    step("R10 start");
    check("R10 com", 64'(comDrive), 64'h57);
    repeat (127) step("R2 period");
    check("R2 still com0", 64'(rowSel), 64'd0);
    step("R5 line flip");
    check("R5 com", 64'(comDrive), 64'hA2);
    // R4 segment mapping on common 1, negative
    for (int s = 0; s < NSEG; s++)
      check("R4 seg map", 64'(segDrive[2*s +: 2]), mem[1][s] ? 64'd3 : 64'd1);
    // R2 other frame lengths, R6 frame inversion
    invMode = 1;
    for (int f = 1; f < 4; f++) begin
      frameSel = 2'(f);
      repeat (3 * 768) step("R6 frame inv");
    end
    invMode = 0;
    // randomized mix
    for (int i = 0; i < 30000; i++) begin
      oscTick = ($urandom % 10) < 7;
      if ($urandom % 500 == 0) frameSel = 2'($urandom);
      if ($urandom % 700 == 0) invMode = ~invMode;
      if ($urandom % 300 == 0) allOn = $urandom;
      if ($urandom % 300 == 0) allOff = $urandom;
      if ($urandom % 3000 == 0) dispOn = ~dispOn;
      if ($urandom % 200 == 0) mem[$urandom % NCOM] = NSEG'($urandom);
      step("R3 R4 R8 random");
    end
    // R8 forcing
    oscTick = 1; dispOn = 1; allOn = 0; allOff = 0;
    while (mState != 1) step("R8 settle");
    allOn = 1;
    step("R8 on");
    check("R8 all lit", 64'(allSegIn(2'd0, 2'd3)), 64'd1);
    allOff = 1;
    step("R8 off wins");
    check("R8 all dark", 64'(allSegIn(2'd1, 2'd2)), 64'd1);
    allOff = 0;
    // R11 no tick holds
    oscTick = 0;
    step("R11 hold");
    comSnap = comDrive; segSnap = segDrive;
    repeat (60) step("R11 hold");
    check("R11 com stable", 64'(comDrive), 64'(comSnap));
    check("R11 seg stable", 64'(segDrive), 64'(segSnap));
    // R7 display off sequence, forcing ignored in exit frame
    oscTick = 1; dispOn = 0;
    while (mState == 1) step("R7 finish frame");
    check("R7 exit starts at com0", 64'(rowSel), 64'd0);
    check("R7 exit dark", 64'(allSegIn(2'd1, 2'd2)), 64'd1);
    while (mState == 2) step("R7 exit frame");
    repeat (5) step("R7 parked");
    check("R7 parked com", 64'(comDrive), 64'd0);
    check("R7 parked seg", 64'(segDrive), 64'd0);
    // R9 blink at the fastest rate
    allOn = 1; blinkSel = 2'd3; dispOn = 1;
    step("R9 start");
    repeat (10239) step("R9 shown");
    check("R9 shown lit", 64'(allSegIn(2'd0, 2'd3)), 64'd1);
    step("R9 dark edge");
    check("R9 dark", 64'(allSegIn(2'd1, 2'd2)), 64'd1);
    repeat (10240) step("R9 dark half");
    check("R9 lit again", 64'(allSegIn(2'd0, 2'd3)), 64'd1);
    blinkSel = 2'd2;
    repeat (25000) step("R9 1Hz");
    blinkSel = 2'd0;
    step("R9 off");
    check("R9 off lit", 64'(allSegIn(2'd0, 2'd3)), 64'd1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule